// File: doc/BRIEF.md
# Channel Hop Table Builder

This block turns a 32-bit seed into a transmitter identity and a table of radio channel numbers used for frequency hopping. On a start request it scrambles the seed with a shift-register mixer to form a 4-byte ID. It then cuts overlapping bit slices out of the ID bytes and adds a base offset to each slice, giving fifteen candidate channels. Each candidate is made distinct from all earlier entries before it is stored.

The work is spread over many clock cycles, one operation per cycle. The candidate for a slot is compared against one earlier entry per clock. On a match the candidate is stepped forward by seven, wrapping back into the legal range if needed, and the scan starts again from slot 0. When the last slot is stored, a one-cycle completion pulse is raised. The finished table can be read at any time through a combinational index port. The ID is available on its own output.

Top module: `hopgen`

## Requirements
- R1: While and after reset, `busy` and `done` are low and every table slot reads 0x00.
- R2: After a run, `idWord` equals the seed put through 33 steps of a right-shifting mixer. Each step shifts the value right by one bit and XORs the result with 0x80200003 when bit 0 was 1 before the shift.
- R3: The ID bytes are numbered from the most significant, so byte k is bits 31-8k down to 24-8k. Slot 4k+s is built from byte k and the next byte n = (k+1) mod 4:
  - s=0: the low six bits of byte k.
  - s=1: byte k shifted right by 2.
  - s=2: byte k shifted right by 4, plus 16 times the low two bits of byte n.
  - s=3: byte k shifted right by 6, plus 4 times the low four bits of byte n.
  Only slots 0 to 14 exist.
- R4: Before the uniqueness step, slots 0 to 7 get a base of 0x03 added and slots 8 to 14 get 0x10.
- R5: Slots are finalised in index order. While a slot's value equals any lower slot's stored value, 7 is added to it. All fifteen stored values are distinct.
- R6: If adding 7 gives 0x50 or more, the value becomes (sum − 0x50 + 0x03). Every stored value lies in 0x03..0x4F.
- R7: The ID 0x7C95C170 yields the table 3F 22 1A 18 1F 28 1C 09 11 40 23 13 47 2C 17.
- R8: `done` is high for exactly one cycle per run, while `busy` is still high. `busy` is low in the following cycle.
- R9: A start sampled while idle raises `busy` in the next cycle. A start sampled while `busy` is high, including the `done` cycle, has no effect on the ID or the table.
- R10: `rdChan` shows the slot selected by `rdIdx` combinationally. Index 15 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request, sampled while idle |
| seed | input | 32 | Seed captured on an accepted start |
| rdIdx | input | 4 | Table slot to read |
| busy | output | 1 | Engine running |
| done | output | 1 | One-cycle completion pulse |
| idWord | output | 32 | Scrambled ID, byte 0 in bits 31:24 |
| rdChan | output | 8 | Channel stored in slot `rdIdx` |

## Verification
The completion pulse and a fresh start request can land in the same cycle. At that moment the engine still reports busy, so the request must be dropped. The bench raises `start` with a different seed exactly in the `done` cycle. It then expects `busy` to be low one cycle later, and expects the ID and all fifteen slots to still match the first seed's model. A second case pulses `start` in the middle of the scan and judges the result the same way.

// File: rtl/hopgen_pkg.sv
package hopgen_pkg;

  localparam int ID_W       = 32;
  localparam int BYTE_W     = 8;
  localparam int ID_BYTES   = ID_W / BYTE_W;
  localparam int SLICES     = 4;
  localparam int CHAN_W     = 8;

  localparam logic [ID_W-1:0]   MIX_TAPS  = 32'h8020_0003;
  localparam logic [CHAN_W-1:0] BASE_LOW  = 8'h03;
  localparam logic [CHAN_W-1:0] BASE_HIGH = 8'h10;
  localparam logic [CHAN_W-1:0] HOP_STEP  = 8'h07;
  localparam logic [CHAN_W-1:0] CHAN_LIM  = 8'h50;
  localparam logic [CHAN_W-1:0] CHAN_MIN  = 8'h03;
  localparam logic [CHAN_W-1:0] CHAN_MAX  = 8'h4F;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MIX,
    ST_LOAD,
    ST_SCAN,
    ST_DONE
  } genState_e;

  typedef struct packed {
    logic loadSeed;
    logic mixStep;
    logic loadEnt;
    logic bump;
    logic commit;
  } ctrlStrobe_t;

endpackage

// File: rtl/hopgen_ctrl.sv
module hopgen_ctrl
  import hopgen_pkg::*;
#(
  parameter int NumChan  = 15,
  parameter int MixIters = 33,
  parameter int IdxW     = $clog2(NumChan)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            scanHit,
  output ctrlStrobe_t     strb,
  output logic [IdxW-1:0] entIdx,
  output logic [IdxW-1:0] scanIdx,
  output logic            busy,
  output logic            done
);

  localparam int IterW = $clog2(MixIters + 1);
  localparam logic [IterW-1:0] LastIter = IterW'(MixIters - 1);
  localparam logic [IdxW-1:0]  LastEnt  = IdxW'(NumChan - 1);

  genState_e       state, stateNxt;
  logic [IterW-1:0] iterCnt;
  logic            lastIter, lastEnt, scanAtSelf;

  assign lastIter   = (iterCnt == LastIter);
  assign lastEnt    = (entIdx == LastEnt);
  assign scanAtSelf = (scanIdx == entIdx);

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.loadSeed = 1'b1;
          stateNxt      = ST_MIX;
        end
      end
      ST_MIX: begin
        strb.mixStep = 1'b1;
        if (lastIter) stateNxt = ST_LOAD;
      end
      ST_LOAD: begin
        strb.loadEnt = 1'b1;
        stateNxt     = ST_SCAN;
      end
      ST_SCAN: begin
        if (scanAtSelf) begin
          strb.commit = 1'b1;
          stateNxt    = lastEnt ? ST_DONE : ST_LOAD;
        end else if (scanHit) begin
          strb.bump = 1'b1;
        end
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      entIdx  <= '0;
      scanIdx <= '0;
    end else begin
      state <= stateNxt;

      if (strb.loadSeed)     iterCnt <= '0;
      else if (strb.mixStep) iterCnt <= iterCnt + 1'b1;

      if (strb.loadSeed)                entIdx <= '0;
      else if (strb.commit && !lastEnt) entIdx <= entIdx + 1'b1;

      if (strb.loadEnt || strb.bump)                       scanIdx <= '0;
      else if (state == ST_SCAN && !strb.commit)           scanIdx <= scanIdx + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/hopgen_dp.sv
module hopgen_dp
  import hopgen_pkg::*;
#(
  parameter int NumChan = 15,
  parameter int IdxW    = $clog2(NumChan)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [ID_W-1:0]   seed,
  input  logic [IdxW-1:0]   entIdx,
  input  logic [IdxW-1:0]   scanIdx,
  input  logic [IdxW-1:0]   rdIdx,
  output logic              scanHit,
  output logic [ID_W-1:0]   idWord,
  output logic [CHAN_W-1:0] curVal,
  output logic [CHAN_W-1:0] rdChan
);

  logic [ID_W-1:0]   idReg;
  logic [BYTE_W-1:0] idByte [ID_BYTES];
  logic [CHAN_W-1:0] rawEnt [NumChan];
  logic [CHAN_W-1:0] tbl    [NumChan];

  function automatic logic [CHAN_W-1:0] bumpChan(input logic [CHAN_W-1:0] v);
    logic [CHAN_W-1:0] sum;
    sum = v + HOP_STEP;
    if (sum >= CHAN_LIM) sum = sum - CHAN_LIM + CHAN_MIN;
    return sum;
  endfunction

  // Byte 0 sits in the most significant position.
  for (genvar b = 0; b < ID_BYTES; b++) begin : g_bytes
    assign idByte[b] = idReg[ID_W-1-BYTE_W*b -: BYTE_W];
  end

  // Slice extraction: four slots per byte, each with a neighbour byte.
  for (genvar b = 0; b < ID_BYTES; b++) begin : g_src
    localparam int Nb = (b + 1) % ID_BYTES;
    localparam logic [CHAN_W-1:0] Base = (b < ID_BYTES / 2) ? BASE_LOW : BASE_HIGH;
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
      localparam int K = b * SLICES + s;
      if (K < NumChan) begin : g_live
        if (s == 0) begin : g_s0
          assign rawEnt[K] = {2'b00, idByte[b][5:0]} + Base;
        end else if (s == 1) begin : g_s1
          assign rawEnt[K] = {2'b00, idByte[b][7:2]} + Base;
        end else if (s == 2) begin : g_s2
          assign rawEnt[K] = {4'b0000, idByte[b][7:4]}
                           + {2'b00, idByte[Nb][1:0], 4'b0000} + Base;
        end else begin : g_s3
          assign rawEnt[K] = {6'b000000, idByte[b][7:6]}
                           + {2'b00, idByte[Nb][3:0], 2'b00} + Base;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idReg  <= '0;
      curVal <= '0;
    end else begin
      if (strb.loadSeed)     idReg <= seed;
      else if (strb.mixStep) idReg <= (idReg >> 1) ^ (idReg[0] ? MIX_TAPS : '0);

      if (strb.loadEnt)   curVal <= rawEnt[entIdx];
      else if (strb.bump) curVal <= bumpChan(curVal);
    end
  end

  for (genvar k = 0; k < NumChan; k++) begin : g_tbl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    tbl[k] <= '0;
      else if (strb.commit && entIdx == IdxW'(k))  tbl[k] <= curVal;
    end
  end

  assign scanHit = (tbl[scanIdx] == curVal);
  assign idWord  = idReg;
  assign rdChan  = (int'(rdIdx) < NumChan) ? tbl[rdIdx] : '0;

endmodule

// File: rtl/hopgen.sv
module hopgen
  import hopgen_pkg::*;
#(
  parameter int NumChan  = 15,
  parameter int MixIters = 33,
  parameter int IdxW     = $clog2(NumChan)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ID_W-1:0]   seed,
  input  logic [IdxW-1:0]   rdIdx,
  output logic              busy,
  output logic              done,
  output logic [ID_W-1:0]   idWord,
  output logic [CHAN_W-1:0] rdChan
);

  ctrlStrobe_t       strb;
  logic [IdxW-1:0]   entIdx, scanIdx;
  logic              scanHit;
  logic [CHAN_W-1:0] curVal;
  logic              tblWr;

  hopgen_ctrl #(.NumChan(NumChan), .MixIters(MixIters), .IdxW(IdxW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .scanHit (scanHit),
    .strb    (strb),
    .entIdx  (entIdx),
    .scanIdx (scanIdx),
    .busy    (busy),
    .done    (done)
  );

  hopgen_dp #(.NumChan(NumChan), .IdxW(IdxW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .seed    (seed),
    .entIdx  (entIdx),
    .scanIdx (scanIdx),
    .rdIdx   (rdIdx),
    .scanHit (scanHit),
    .idWord  (idWord),
    .curVal  (curVal),
    .rdChan  (rdChan)
  );

  assign tblWr = strb.commit;

endmodule

// File: rtl/hopgen_chk.sv
module hopgen_chk
  import hopgen_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              tblWr,
  input logic [CHAN_W-1:0] wrData
);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R9
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !done));

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R6
  chan_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    tblWr |-> (wrData >= CHAN_MIN && wrData <= CHAN_MAX));

  // R5
  write_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    tblWr |-> (busy && !done));

endmodule

bind hopgen hopgen_chk u_hopgenChk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .tblWr  (tblWr),
  .wrData (curVal)
);

// File: tb/hopgen_bench.sv
`timescale 1ns/1ps
module hopgen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] seed = '0;
  logic [3:0]  rdIdx = '0;
  logic        busy, done;
  logic [31:0] idWord;
  logic [7:0]  rdChan;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hopgen u_hopgen (
    .clk(clk), .rstN(rstN), .start(start), .seed(seed), .rdIdx(rdIdx),
    .busy(busy), .done(done), .idWord(idWord), .rdChan(rdChan)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(input logic [31:0] s);
    logic [31:0] v = s;
    for (int i = 0; i < 33; i++) v = (v >> 1) ^ (v[0] ? 32'h8020_0003 : 32'h0);
    return v;
  endfunction

  function automatic logic [31:0] unmix(input logic [31:0] s);
    logic [31:0] v = s;
    for (int i = 0; i < 33; i++) begin
      logic lsb = v[31];
      logic [31:0] t = v ^ (lsb ? 32'h8020_0003 : 32'h0);
      v = {t[30:0], lsb};
    end
    return v;
  endfunction

  task automatic model(input logic [31:0] id, output logic [7:0] m [15]);
    int by [4];
    for (int k = 0; k < 4; k++) by[k] = int'(id[31-8*k -: 8]);
    for (int k = 0; k < 4; k++) begin
      int n = (k + 1) % 4;
      int base = (k < 2) ? 3 : 16;
      int r [4];
      r[0] = (by[k] & 63) + base;
      r[1] = (by[k] >> 2) + base;
      r[2] = (by[k] >> 4) + (by[n] & 3) * 16 + base;
      r[3] = (by[k] >> 6) + (by[n] & 15) * 4 + base;
      for (int s = 0; s < 4; s++) if (k*4+s < 15) m[k*4+s] = 8'(r[s]);
    end
    for (int i = 1; i < 15; i++) begin
      bit clash = 1;
      while (clash) begin
        clash = 0;
        for (int j = 0; j < i; j++) if (m[i] == m[j]) clash = 1;
        if (clash) begin
          int v = int'(m[i]) + 7;
          if (v >= 80) v = v - 80 + 3;
          m[i] = 8'(v);
        end
      end
    end
  endtask

  // Starts a run; returns after the cycle in which done was seen plus one.
  task automatic runGen(input logic [31:0] s, input bit pokeMid,
                        input bit pokeDone, input logic [31:0] other);
    int n = 0;
    @(negedge clk);
    seed = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0; seed = other;
    chk(busy === 1'b1 && done === 1'b0, "R9 start accepted", {31'b0, busy}, 1);
    if (pokeMid) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, "R8 done reached", {31'b0, done}, 1);
    chk(busy === 1'b1, "R8 busy during done", {31'b0, busy}, 1);
    if (pokeDone) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b0, "R8 done one cycle", {31'b0, done}, 0);
    chk(busy === 1'b0, "R9 idle after done", {31'b0, busy}, 0);
  endtask

  task automatic checkTable(input logic [31:0] s, input string req);
    logic [7:0] m [15];
    logic [31:0] id = mix(s);
    chk(idWord === id, "R2 scrambled id", idWord, id);
    model(id, m);
    for (int k = 0; k < 15; k++) begin
      rdIdx = 4'(k);
      #1;
      chk(rdChan === m[k], req, {24'b0, rdChan}, {24'b0, m[k]});
      chk(rdChan >= 8'h03 && rdChan <= 8'h4F, "R6 range", {24'b0, rdChan}, 32'h03);
    end
    for (int a = 0; a < 15; a++)
      for (int b = a + 1; b < 15; b++)
        if (m[a] == m[b]) chk(0, "R5 model distinct", a, b);
  endtask

  task automatic testReset();
    chk(busy === 1'b0 && done === 1'b0, "R1 reset outputs", {30'b0, busy, done}, 0);
    for (int k = 0; k < 15; k++) begin
      rdIdx = 4'(k);
      #1;
      chk(rdChan === 8'h00, "R1 table cleared", {24'b0, rdChan}, 0);
    end
  endtask

  task automatic testExample();
    logic [7:0] exp [15] = '{8'h3F, 8'h22, 8'h1A, 8'h18, 8'h1F, 8'h28, 8'h1C, 8'h09,
                             8'h11, 8'h40, 8'h23, 8'h13, 8'h47, 8'h2C, 8'h17};
    logic [31:0] s = unmix(32'h7C95_C170);
    runGen(s, 0, 0, 32'h0);
    chk(idWord === 32'h7C95_C170, "R7 example id", idWord, 32'h7C95_C170);
    for (int k = 0; k < 15; k++) begin
      rdIdx = 4'(k);
      #1;
      chk(rdChan === exp[k], "R7 example table", {24'b0, rdChan}, {24'b0, exp[k]});
    end
  endtask

  task automatic testSeeds();
    logic [31:0] seeds [5] = '{32'h1234_5678, 32'hB2C5_4A2F, 32'h0000_0001,
                               32'hDEAD_BEEF, 32'h0F0F_A5A5};
    for (int i = 0; i < 5; i++) begin
      runGen(seeds[i], 0, 0, 32'h0);
      checkTable(seeds[i], "R3 R4 R5 slot value");
    end
    runGen(unmix(32'h0000_0000), 0, 0, 32'h0);
    checkTable(unmix(32'h0000_0000), "R5 heavy clash table");
  endtask

  task automatic testWrap();
    // All slices equal 0x42 / 0x4F: repeated +7 crosses 0x50 and wraps.
    runGen(unmix(32'hFFFF_FFFF), 0, 0, 32'h0);
    checkTable(unmix(32'hFFFF_FFFF), "R6 wrap table");
    rdIdx = 4'd2;
    #1;
    chk(rdChan === 8'h03, "R6 wrapped slot", {24'b0, rdChan}, 32'h03);
  endtask

  task automatic testIgnoreBusy();
    runGen(32'hCAFE_0001, 1, 0, 32'h5555_AAAA);
    checkTable(32'hCAFE_0001, "R9 mid-run start ignored");
  endtask

  task automatic testDoneCollision();
    runGen(32'h0BAD_F00D, 0, 1, 32'h7777_1111);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R9 start in done cycle dropped", {31'b0, busy}, 0);
    checkTable(32'h0BAD_F00D, "R9 table kept");
  endtask

  task automatic testOutOfRange();
    rdIdx = 4'd15;
    #1;
    chk(rdChan === 8'h00, "R10 index 15 reads zero", {24'b0, rdChan}, 0);
    rdIdx = 4'd0;
    #1;
    chk(rdChan !== 8'h00, "R10 index 0 readback", {24'b0, rdChan}, 32'h1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testExample();
    testSeeds();
    testWrap();
    testIgnoreBusy();
    testDoneCollision();
    testOutOfRange();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule